// File: doc/BRIEF.md
# Interrupt Daisy-Chain Priority Controller

This block is the interrupt front end of a peripheral that holds two internal interrupt sources: a serial unit, which has several request types, and a DMA unit, which has a few request types of its own. The block sits on a priority chain of devices. A pass signal arrives from the device above and a pass signal goes out to the device below. The block also drives an active-low interrupt line towards the processor.

When the processor runs an acknowledge cycle, the block settles which device on the chain answers. It answers only when the pass signal from above is high. The serial unit wins over the DMA unit. The block then marks the winning source as in service. On the falling edge of the read strobe it returns an 8-bit vector. Optionally, three bits of that vector are replaced with a code that names the request which won. Software releases the in-service mark with a one-cycle command, and that command always clears the highest-priority mark that is set. A master enable input takes the block off the chain completely.

Top module: `intr_chain_ctrl`

## Requirements
- R1: After reset no source is in service, `irq_n` is 1, `vec_oe` is 0 and `vec_out` is 0.
- R2: `irq_n` is low one clock after a cycle in which `mie` is 1 and any bit of `ser_req` or `dma_req` is 1. `irq_n` is high one clock after a cycle in which that does not hold, which includes every cycle with `mie` at 0.
- R3: While `mie` is 0, `chain_out` equals `chain_in` in the same cycle, whatever the other inputs are.
- R4: While `mie` is 1 and `ack_n` is 1, `chain_out` is high exactly when `chain_in` is high and no source is in service.
- R5: While `mie` is 1, `ack_n` is 0 and any request is pending, `chain_out` is low.
- R6: A claim happens only on the clock edge where `rd_n` is sampled low after being sampled high, and only while `ack_n` is 0, `mie` is 1 and `chain_in` is 1. Without a claim, `vec_oe` stays at 0 and no in-service mark is set.
- R7: At a claim, a pending serial request wins whenever the serial unit is not already in service, even if the DMA unit is in service. A DMA request wins only when no serial request is pending and neither source is in service.
- R8: When `vec_mod` is 1, the returned vector is `base_vec` with bits 3:1 replaced by a source code. The serial request at index i gives code i, and index 0 has the highest priority. The DMA request at index j gives code 4+j, and index 0 has the highest priority. When `vec_mod` is 0, the vector equals `base_vec`.
- R9: `vec_oe` rises in the clock after the claim edge. It stays high until the clock after `ack_n` or `rd_n` is sampled high. `vec_out` is 0 whenever `vec_oe` is 0.
- R10: A one-cycle `ius_clr` clears the highest-priority in-service mark: the serial mark if it is set, otherwise the DMA mark. When `ius_clr` and a claim fall on the same edge, the clear acts on the marks held before that edge, and the new mark is set as well.
- R11: While `mie` is 0, an acknowledge cycle produces no vector and sets no in-service mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mie | input | 1 | Master interrupt enable |
| vec_mod | input | 1 | Put the source code into vector bits 3:1 |
| base_vec | input | 8 | Programmed base vector |
| ser_req | input | 4 | Serial-unit request types, index 0 highest priority |
| dma_req | input | 2 | DMA-unit request types, index 0 highest priority |
| ius_clr | input | 1 | Pulse that clears the highest in-service mark |
| chain_in | input | 1 | Pass signal from the higher-priority device, active high |
| chain_out | output | 1 | Pass signal to the lower-priority device, active high |
| ack_n | input | 1 | Acknowledge cycle strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| irq_n | output | 1 | Interrupt request, actively driven, active low |
| vec_oe | output | 1 | Vector is valid on `vec_out` |
| vec_out | output | 8 | Returned vector, zero when not valid |

## Verification
The clear command and a new claim can land on the same clock edge. In that case the clear must act on the marks that existed before the edge, and the claim's mark must still be set afterwards. The bench first places the DMA unit in service. It then raises `ius_clr` together with the read-strobe fall of an acknowledge cycle in which a serial request is pending. It then judges the outcome at the ports. The serial vector must appear. `chain_out` must stay low afterwards, which shows the serial mark survived. One further clear must then bring `chain_out` high, which shows the DMA mark had been removed.

// File: rtl/intr_chain_pkg.sv
package intr_chain_pkg;

    parameter int VEC_W    = 8;
    parameter int CODE_W   = 3;
    parameter int CODE_LSB = 1;

    localparam int MARK_SER = 1;
    localparam int MARK_DMA = 0;

    typedef struct packed {
        logic [1:0]       marks;
        logic             irq;
        logic             rd_q;
        logic             oe;
        logic [VEC_W-1:0] vec;
    } chain_state_t;

endpackage

// File: rtl/intr_prio_enc.sv
module intr_prio_enc #(
    parameter int N = 4,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // lowest index wins
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/intr_vec_fmt.sv
module intr_vec_fmt
    import intr_chain_pkg::*;
(
    input  logic [VEC_W-1:0]  base,
    input  logic [CODE_W-1:0] code,
    input  logic              en,
    output logic [VEC_W-1:0]  vec
);

    always_comb begin
        vec = base;
        if (en) begin
            vec[CODE_LSB +: CODE_W] = code;
        end
    end

endmodule

// File: rtl/intr_chain_ctrl.sv
module intr_chain_ctrl
    import intr_chain_pkg::*;
#(
    parameter int N_SER = 4,
    parameter int N_DMA = 2,
    localparam int SER_IW = (N_SER > 1) ? $clog2(N_SER) : 1,
    localparam int DMA_IW = (N_DMA > 1) ? $clog2(N_DMA) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mie,
    input  logic             vec_mod,
    input  logic [VEC_W-1:0] base_vec,
    input  logic [N_SER-1:0] ser_req,
    input  logic [N_DMA-1:0] dma_req,
    input  logic             ius_clr,
    input  logic             chain_in,
    output logic             chain_out,
    input  logic             ack_n,
    input  logic             rd_n,
    output logic             irq_n,
    output logic             vec_oe,
    output logic [VEC_W-1:0] vec_out
);

    chain_state_t s_d, s_q;

    logic              ser_any, dma_any;
    logic [SER_IW-1:0] ser_idx;
    logic [DMA_IW-1:0] dma_idx;
    logic [CODE_W-1:0] sel_code;
    logic [VEC_W-1:0]  fmt_vec;
    logic              pend;

    intr_prio_enc #(.N(N_SER)) u_ser_enc (
        .req (ser_req),
        .any (ser_any),
        .idx (ser_idx)
    );

    intr_prio_enc #(.N(N_DMA)) u_dma_enc (
        .req (dma_req),
        .any (dma_any),
        .idx (dma_idx)
    );

    // serial codes start at 0, DMA codes follow the serial range
    assign sel_code = ser_any ? CODE_W'(ser_idx)
                              : CODE_W'(N_SER) + CODE_W'(dma_idx);

    intr_vec_fmt u_fmt (
        .base (base_vec),
        .code (sel_code),
        .en   (vec_mod),
        .vec  (fmt_vec)
    );

    assign pend = mie & (ser_any | dma_any);

    always_comb begin
        logic       take, claim_ser, claim_dma;
        logic [1:0] clr;

        s_d      = s_q;
        s_d.irq  = pend;
        s_d.rd_q = rd_n;

        take      = ~rd_n & s_q.rd_q & ~ack_n & mie & chain_in;
        claim_ser = take & ser_any & ~s_q.marks[MARK_SER];
        claim_dma = take & ~ser_any & dma_any & (s_q.marks == 2'b00);

        clr = 2'b00;
        if (ius_clr) begin
            if (s_q.marks[MARK_SER]) begin
                clr[MARK_SER] = 1'b1;
            end else if (s_q.marks[MARK_DMA]) begin
                clr[MARK_DMA] = 1'b1;
            end
        end

        s_d.marks = s_q.marks & ~clr;
        s_d.marks[MARK_SER] = s_d.marks[MARK_SER] | claim_ser;
        s_d.marks[MARK_DMA] = s_d.marks[MARK_DMA] | claim_dma;

        if (claim_ser | claim_dma) begin
            s_d.oe  = 1'b1;
            s_d.vec = fmt_vec;
        end else if (ack_n | rd_n) begin
            s_d.oe  = 1'b0;
            s_d.vec = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.rd_q <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign chain_out = mie ? (chain_in & ~(|s_q.marks) & ~(~ack_n & pend))
                           : chain_in;
    assign irq_n     = ~s_q.irq;
    assign vec_oe    = s_q.oe;
    assign vec_out   = s_q.oe ? s_q.vec : '0;

endmodule

module intr_chain_ctrl_chk #(
    parameter int N_SER = 4,
    parameter int N_DMA = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mie,
    input logic [N_SER-1:0] ser_req,
    input logic [N_DMA-1:0] dma_req,
    input logic             chain_in,
    input logic             chain_out,
    input logic             ack_n,
    input logic             irq_n,
    input logic             vec_oe,
    input logic [7:0]       vec_out
);

    p_irq_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mie && ((|ser_req) || (|dma_req))) |=> !irq_n);

    p_irq_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mie |=> irq_n);

    p_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mie |-> (chain_out == chain_in));

    p_ack_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mie && !ack_n && ((|ser_req) || (|dma_req))) |-> !chain_out);

    p_claim_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_oe) |-> ($past(chain_in) && $past(!ack_n) && $past(mie)));

    p_served_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(vec_oe) && mie) |-> !chain_out);

    p_oe_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |=> !vec_oe);

    p_vec_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_oe |-> (vec_out == 8'h00));

endmodule

bind intr_chain_ctrl intr_chain_ctrl_chk #(.N_SER(N_SER), .N_DMA(N_DMA)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mie       (mie),
    .ser_req   (ser_req),
    .dma_req   (dma_req),
    .chain_in  (chain_in),
    .chain_out (chain_out),
    .ack_n     (ack_n),
    .irq_n     (irq_n),
    .vec_oe    (vec_oe),
    .vec_out   (vec_out)
);

// File: tb/intr_chain_ctrl_bench.sv
module intr_chain_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mie = 1'b0;
    logic       vec_mod = 1'b0;
    logic [7:0] base_vec = 8'h00;
    logic [3:0] ser_req = 4'h0;
    logic [1:0] dma_req = 2'b00;
    logic       ius_clr = 1'b0;
    logic       chain_in = 1'b1;
    logic       chain_out;
    logic       ack_n = 1'b1;
    logic       rd_n = 1'b1;
    logic       irq_n;
    logic       vec_oe;
    logic [7:0] vec_out;

    int n_cmp = 0;
    int n_bad = 0;
    int n_seen = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    logic prev_oe = 1'b0;

    always #10 clk = ~clk;

    intr_chain_ctrl u_intr_chain_ctrl (
        .clk(clk), .rst_n(rst_n), .mie(mie), .vec_mod(vec_mod),
        .base_vec(base_vec), .ser_req(ser_req), .dma_req(dma_req),
        .ius_clr(ius_clr), .chain_in(chain_in), .chain_out(chain_out),
        .ack_n(ack_n), .rd_n(rd_n), .irq_n(irq_n), .vec_oe(vec_oe),
        .vec_out(vec_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pop one expected vector on each rising vec_oe
    always @(negedge clk) begin
        if (rst_n) begin
            if (vec_oe && !prev_oe) begin
                n_seen++;
                if (exp_q.size() == 0) begin
                    chk("R6 unexpected vector", vec_out, 8'hxx);
                end else begin
                    chk("R8 vector", vec_out, exp_q.pop_front());
                end
            end
            prev_oe = vec_oe;
        end
    end

    task automatic ack_cycle(input bit exp_claim, input logic [7:0] exp_vec, input bit clr_at_claim);
        int seen0;
        seen0 = n_seen;
        if (exp_claim) exp_q.push_back(exp_vec);
        @(negedge clk); ack_n = 1'b0; rd_n = 1'b1;
        @(negedge clk); rd_n = 1'b0; ius_clr = clr_at_claim;
        @(negedge clk); ius_clr = 1'b0;
        chk("R9 oe after claim edge", {7'd0, vec_oe}, {7'd0, exp_claim});
        @(negedge clk);
        chk("R9 oe held while strobes low", {7'd0, vec_oe}, {7'd0, exp_claim});
        rd_n = 1'b1; ack_n = 1'b1;
        @(negedge clk);
        chk("R9 oe drops after release", {7'd0, vec_oe}, 8'h00);
        chk("R9 vec zero when idle", vec_out, 8'h00);
        chk("R6 claim count", 8'(n_seen - seen0), {7'd0, exp_claim});
    endtask

    task automatic pulse_clr();
        @(negedge clk); ius_clr = 1'b1;
        @(negedge clk); ius_clr = 1'b0;
    endtask

    task automatic chain_idle(input string req, input logic exp);
        @(negedge clk); chain_in = 1'b1; #1;
        chk(req, {7'd0, chain_out}, {7'd0, exp});
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        chk("R1 vec_oe after reset", {7'd0, vec_oe}, 8'h00);
        chk("R1 vec_out after reset", vec_out, 8'h00);

        // mie off: bypass and silence
        chain_in = 1'b0; ack_n = 1'b0; ser_req = 4'h1; #1;
        chk("R3 bypass low", {7'd0, chain_out}, 8'h00);
        chain_in = 1'b1; #1;
        chk("R3 bypass high with ack and request", {7'd0, chain_out}, 8'h01);
        ack_n = 1'b1;
        @(negedge clk);
        chk("R2 irq_n high with mie off", {7'd0, irq_n}, 8'h01);
        ack_cycle(1'b0, 8'h00, 1'b0);   // R11 no claim while disabled
        chain_idle("R11 no mark after disabled ack", 1'b1);

        // enable, irq timing
        ser_req = 4'h0;
        @(negedge clk); mie = 1'b1;
        @(negedge clk);
        chk("R2 irq_n high no request", {7'd0, irq_n}, 8'h01);
        ser_req = 4'b0100;
        @(negedge clk);
        chk("R2 irq_n low one clock after request", {7'd0, irq_n}, 8'h00);
        chain_idle("R4 chain passes with nothing served", 1'b1);
        ack_n = 1'b0; #1;
        chk("R5 chain blocked in ack with request", {7'd0, chain_out}, 8'h00);
        ack_n = 1'b1;

        // chain_in low: no claim
        @(negedge clk); chain_in = 1'b0; #1;
        chk("R4 chain low follows chain_in", {7'd0, chain_out}, 8'h00);
        ack_cycle(1'b0, 8'h00, 1'b0);   // R6
        chain_idle("R6 no mark without chain_in", 1'b1);

        // serial claim with encoding: idx 2 -> code 2
        vec_mod = 1'b1; base_vec = 8'hA0;
        ack_cycle(1'b1, 8'hA4, 1'b0);
        chain_idle("R4 chain low while serial served", 1'b0);
        pulse_clr();
        chain_idle("R10 clear releases serial", 1'b1);

        // serial beats DMA, encoding off
        ser_req = 4'b1000; dma_req = 2'b10;
        vec_mod = 1'b0; base_vec = 8'h5E;
        ack_cycle(1'b1, 8'h5E, 1'b0);   // R7, R8 plain
        pulse_clr();
        chain_idle("R10 clear after serial win", 1'b1);

        // DMA alone: code 4 + 0
        ser_req = 4'h0; dma_req = 2'b01;
        vec_mod = 1'b1; base_vec = 8'h31;
        ack_cycle(1'b1, 8'h39, 1'b0);
        // serial preempts DMA in service: code 0
        ser_req = 4'b0001;
        ack_cycle(1'b1, 8'h31, 1'b0);   // R7 preempt
        // DMA cannot claim while marks are set
        ser_req = 4'h0; dma_req = 2'b10;
        ack_cycle(1'b0, 8'h00, 1'b0);   // R7 blocked
        pulse_clr();
        chain_idle("R10 one clear leaves DMA mark", 1'b0);
        pulse_clr();
        chain_idle("R10 second clear frees chain", 1'b1);

        // DMA idx 1 -> code 5
        ack_cycle(1'b1, 8'h3B, 1'b0);
        // collision: clear and serial claim on the same edge
        ser_req = 4'b0010;
        ack_cycle(1'b1, 8'h33, 1'b1);
        chain_idle("R10 serial mark kept after same-edge clear", 1'b0);
        pulse_clr();
        chain_idle("R10 DMA mark was cleared at collision", 1'b1);

        // drop requests, irq returns high
        ser_req = 4'h0; dma_req = 2'b00;
        @(negedge clk);
        chk("R2 irq_n high after requests drop", {7'd0, irq_n}, 8'h01);
        chk("R8 no leftover expected vectors", 8'(exp_q.size()), 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule